// File: doc/BRIEF.md
# Codec Reset and ADC Offset Calibration Sequencer

This block sequences power-up of an audio codec's ADC path. While the active-low power-down input is held low, every control register goes back to its default, the calibration result is discarded and both gain stages are muted. When that input is released, a calibration window opens. The window is counted in sample-rate ticks and lasts 4128 sample periods. During the window the ADC outputs of both channels read as two's-complement zero. The final 4096 samples of each channel are averaged into an offset value, which is then subtracted from every later sample. This averaging is a digital stand-in for the analog offset estimate.

A register write port sets the codec controls. While the window runs, a write to the guarded address is dropped, and a sticky flag records that this happened. The gain stages stay muted after the window closes. They are released only when the mute register is written after calibration has completed. Clearing the power-management bits in register 0 does not discard the calibration result. Only the power-down input can discard it.

Top module: `codec_cal_seq`

## Requirements
- R1: While `pdn_n` is low, `ctl_regs` holds its defaults: register 0 = 0x09 and registers 1, 2 and 3 = 0x00, with register k in bits [8k+7:8k]. In the same state, `cal_valid` and `guard_drop` are 0, and `cal_busy`, `in_gain_mute` and `out_gain_mute` are 1.
- R2: `cal_busy` stays high from the release of `pdn_n` until the clock edge that registers the 4128th `fs_tick` since that release. On that edge `cal_busy` falls and `cal_valid` rises. Later ticks never raise `cal_busy` again; only a new pulse on `pdn_n` does.
- R3: While `cal_busy` is high, both channel fields of `adc_out` are zero. Channel 0 is bits [15:0] and channel 1 is bits [31:16].
- R4: `in_gain_mute` and `out_gain_mute` stay high during and after calibration. Each is released only by a write to address 2 made while `cal_valid` is 1: bit 0 set unmutes the input stage, and bit 1 set unmutes the output stage. Writing 0 to a bit mutes that stage again. A write to address 2 made before `cal_valid` is set is stored in the register but unmutes nothing.
- R5: A write to address 1 while `cal_busy` is high leaves register 1 unchanged. It also sets `guard_drop`, which then stays high until `pdn_n` goes low.
- R6: With `pdn_n` high, any other write to addresses 0 to 3 appears in `ctl_regs` on the next cycle. A write to address 1 made after calibration is also accepted. A write to an address of 4 or above changes nothing.
- R7: Each channel's offset is the floor of the mean of that channel's samples taken at the last 4096 ticks of the window. After calibration, each output equals its input minus its offset, saturated to the signed 16-bit range.
- R8: Clearing bit 0 of register 0 (ADC power) forces `adc_out` to zero. Clearing bit 3 of register 0 (auxiliary power) has no effect on the ADC path. Neither bit changes `cal_valid` or the stored offsets, so setting bit 0 again brings back the corrected output without a new window. `cal_valid` falls only on `pdn_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pdn_n | input | 1 | Active-low power-down; asynchronous reset, release starts calibration |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| adc_in | input | 32 | Raw ADC samples, channel 0 in the low half |
| adc_out | output | 32 | Gated, offset-corrected ADC samples |
| in_gain_mute | output | 1 | Input gain stage mute |
| out_gain_mute | output | 1 | Output gain stage mute |
| cal_busy | output | 1 | Calibration window open |
| cal_valid | output | 1 | Calibration result held |
| guard_drop | output | 1 | Sticky: a guarded write was dropped |
| ctl_regs | output | 32 | Control register contents, register k in bits [8k+7:8k] |

## Verification
The bench targets four corner cases.

- **Window length:** it checks that the window ends on exactly the 4128th tick. A counter that is one tick long or short would unmute too early or release the outputs one sample off, so the cycle-accurate comparison catches it.
- **Write timing around the window:** it writes the guarded and mute addresses while the window is open and again after it closes. A design that accepted the guarded write, or unmuted on a write made before calibration completed, shows up in `ctl_regs` and the mute pins.
- **Saturation:** it calibrates against large constant offsets and then drives full-scale inputs. A subtraction without saturation wraps to the opposite sign.
- **Reset and power-down:** it aborts a window with a short power-down pulse, and it clears the power-management bits after calibration. Together these separate a flag cleared only by `pdn_n` from one that also follows register bits.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   // Window state of the calibration sequencer
   typedef enum logic [0:0] {
      WIN_DONE = 1'b0,
      WIN_RUN  = 1'b1
   } win_state_e;

   localparam int unsigned CAL_LEN_STD  = 4128;
   localparam int unsigned AVG_SH_STD   = 12;

endpackage

// File: rtl/cal_window_ctr.sv
module cal_window_ctr
   import cal_seq_pkg::*;
#(
   parameter int unsigned CAL_LEN = CAL_LEN_STD,
   parameter int unsigned AVG_SH  = AVG_SH_STD
) (
   input  logic clk,
   input  logic pdn_n,
   input  logic fs_tick,
   output logic busy,
   output logic valid,
   output logic done,
   output logic avg_take
);

   localparam int unsigned CW = $clog2(CAL_LEN);
   localparam logic [CW-1:0] LAST_IDX  = CW'(CAL_LEN - 1);
   localparam logic [CW-1:0] AVG_START = CW'(CAL_LEN - (1 << AVG_SH));

   win_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          valid_q;

   assign busy     = (state_q == WIN_RUN);
   assign valid    = valid_q;
   assign done     = busy && fs_tick && (cnt_q == LAST_IDX);
   assign avg_take = busy && fs_tick && (cnt_q >= AVG_START);

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         state_q <= WIN_RUN;
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (busy && fs_tick) begin
         if (cnt_q == LAST_IDX) begin
            state_q <= WIN_DONE;
            valid_q <= 1'b1;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   // R2: the window closing always leaves a valid result behind
   a_r2_close_sets_valid: assert property (@(posedge clk) disable iff (!pdn_n)
      $fell(busy) |-> valid);

   // R2: once closed, the window never reopens without a power-down pulse
   a_r2_no_reopen: assert property (@(posedge clk) disable iff (!pdn_n)
      !busy |=> !busy);

   // R8: the result flag is only cleared by the power-down pin
   a_r8_valid_holds: assert property (@(posedge clk) disable iff (!pdn_n)
      valid |=> valid);

endmodule

// File: rtl/cal_offset_mem.sv
module cal_offset_mem #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned AVG_SH   = 12
) (
   input  logic                       clk,
   input  logic                       pdn_n,
   input  logic                       take,
   input  logic                       done,
   input  logic signed [SAMPLE_W-1:0] sample,
   output logic signed [SAMPLE_W-1:0] offset
);

   localparam int unsigned AW = SAMPLE_W + AVG_SH;

   logic signed [AW-1:0] acc_q;
   logic signed [AW-1:0] acc_nxt;
   logic signed [SAMPLE_W-1:0] off_q;

   assign acc_nxt = acc_q + {{AVG_SH{sample[SAMPLE_W-1]}}, sample};
   assign offset  = off_q;

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         acc_q <= '0;
         off_q <= '0;
      end else if (take) begin
         if (done) begin
            // upper bits of the sum: floor of the mean
            off_q <= acc_nxt[AW-1:AVG_SH];
            acc_q <= '0;
         end else begin
            acc_q <= acc_nxt;
         end
      end
   end

   // R7: the stored offset only moves on the closing tick of the window
   a_r7_offset_frozen: assert property (@(posedge clk) disable iff (!pdn_n)
      !done |=> offset == $past(offset));

endmodule

// File: rtl/cal_adc_gate.sv
module cal_adc_gate #(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                       force_zero,
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic signed [SAMPLE_W-1:0] offset,
   output logic signed [SAMPLE_W-1:0] result
);

   localparam logic signed [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic signed [SAMPLE_W:0] diff;

   assign diff = {sample[SAMPLE_W-1], sample} - {offset[SAMPLE_W-1], offset};

   always_comb begin
      if (force_zero) begin
         result = '0;
      end else if (diff[SAMPLE_W] != diff[SAMPLE_W-1]) begin
         result = diff[SAMPLE_W] ? MIN_V : MAX_V;
      end else begin
         result = diff[SAMPLE_W-1:0];
      end
   end

endmodule

// File: rtl/cal_ctl_regs.sv
module cal_ctl_regs #(
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned REG_W        = 8,
   parameter int unsigned NUM_REGS     = 4,
   parameter logic [NUM_REGS*REG_W-1:0] DEFAULTS = '0,
   parameter int unsigned GUARD_ADDR   = 1,
   parameter int unsigned MUTE_ADDR    = 2,
   parameter int unsigned IN_MUTE_BIT  = 0,
   parameter int unsigned OUT_MUTE_BIT = 1
) (
   input  logic                      clk,
   input  logic                      pdn_n,
   input  logic                      busy,
   input  logic                      valid,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [REG_W-1:0]          wr_data,
   output logic [NUM_REGS*REG_W-1:0] regs_flat,
   output logic                      drop,
   output logic                      in_arm,
   output logic                      out_arm
);

   logic guard_hit;
   logic mute_hit;
   logic drop_q;
   logic in_arm_q;
   logic out_arm_q;

   assign guard_hit = wr_en && (wr_addr == ADDR_W'(GUARD_ADDR));
   assign mute_hit  = wr_en && (wr_addr == ADDR_W'(MUTE_ADDR)) && valid;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam bit IS_GUARD = (i == GUARD_ADDR);
      logic [REG_W-1:0] q;
      logic             take;

      assign take = wr_en && (wr_addr == ADDR_W'(i)) && !(IS_GUARD && busy);

      always_ff @(posedge clk or negedge pdn_n) begin
         if (!pdn_n) begin
            q <= DEFAULTS[i*REG_W +: REG_W];
         end else if (take) begin
            q <= wr_data;
         end
      end

      assign regs_flat[i*REG_W +: REG_W] = q;
   end

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         drop_q    <= 1'b0;
         in_arm_q  <= 1'b0;
         out_arm_q <= 1'b0;
      end else begin
         if (guard_hit && busy) begin
            drop_q <= 1'b1;
         end
         if (mute_hit) begin
            in_arm_q  <= wr_data[IN_MUTE_BIT];
            out_arm_q <= wr_data[OUT_MUTE_BIT];
         end
      end
   end

   assign drop    = drop_q;
   assign in_arm  = in_arm_q;
   assign out_arm = out_arm_q;

   // R5: a guarded write during the window leaves the register as it was
   a_r5_guard_hold: assert property (@(posedge clk) disable iff (!pdn_n)
      (guard_hit && busy) |=> regs_flat[GUARD_ADDR*REG_W +: REG_W] ==
                              $past(regs_flat[GUARD_ADDR*REG_W +: REG_W]));

   // R5: the drop record is sticky until power-down
   a_r5_drop_sticky: assert property (@(posedge clk) disable iff (!pdn_n)
      drop |=> drop);

   // R4: no stage can be armed while the result is missing
   a_r4_no_early_arm: assert property (@(posedge clk) disable iff (!pdn_n)
      !valid |-> !in_arm && !out_arm);

endmodule

// File: rtl/codec_cal_seq.sv
module codec_cal_seq
   import cal_seq_pkg::*;
#(
   parameter int unsigned CAL_LEN      = CAL_LEN_STD,
   parameter int unsigned AVG_SH       = AVG_SH_STD,
   parameter int unsigned SAMPLE_W     = 16,
   parameter int unsigned NUM_CH       = 2,
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned REG_W        = 8,
   parameter int unsigned NUM_REGS     = 4,
   parameter logic [NUM_REGS*REG_W-1:0] REG_DEFAULTS = 32'h0000_0009,
   parameter int unsigned PM_ADDR      = 0,
   parameter int unsigned PM_ADC_BIT   = 0,
   parameter int unsigned GUARD_ADDR   = 1,
   parameter int unsigned MUTE_ADDR    = 2,
   parameter int unsigned IN_MUTE_BIT  = 0,
   parameter int unsigned OUT_MUTE_BIT = 1
) (
   input  logic                       clk,
   input  logic                       pdn_n,
   input  logic                       fs_tick,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [REG_W-1:0]           wr_data,
   input  logic [NUM_CH*SAMPLE_W-1:0] adc_in,
   output logic [NUM_CH*SAMPLE_W-1:0] adc_out,
   output logic                       in_gain_mute,
   output logic                       out_gain_mute,
   output logic                       cal_busy,
   output logic                       cal_valid,
   output logic                       guard_drop,
   output logic [NUM_REGS*REG_W-1:0]  ctl_regs
);

   // elaboration-time parameter checks
   if ((1 << AVG_SH) > CAL_LEN) begin : g_bad_avg
      $error("averaging span exceeds calibration window");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("register count exceeds address space");
   end
   if (GUARD_ADDR >= NUM_REGS || MUTE_ADDR >= NUM_REGS || PM_ADDR >= NUM_REGS) begin : g_bad_addr
      $error("special register address outside register file");
   end
   if (IN_MUTE_BIT >= REG_W || OUT_MUTE_BIT >= REG_W || PM_ADC_BIT >= REG_W) begin : g_bad_bit
      $error("control bit outside register width");
   end

   logic busy;
   logic valid;
   logic done;
   logic avg_take;
   logic in_arm;
   logic out_arm;
   logic adc_pwr;
   logic force_zero;

   cal_window_ctr #(
      .CAL_LEN (CAL_LEN),
      .AVG_SH  (AVG_SH)
   ) u_win (
      .clk      (clk),
      .pdn_n    (pdn_n),
      .fs_tick  (fs_tick),
      .busy     (busy),
      .valid    (valid),
      .done     (done),
      .avg_take (avg_take)
   );

   cal_ctl_regs #(
      .ADDR_W       (ADDR_W),
      .REG_W        (REG_W),
      .NUM_REGS     (NUM_REGS),
      .DEFAULTS     (REG_DEFAULTS),
      .GUARD_ADDR   (GUARD_ADDR),
      .MUTE_ADDR    (MUTE_ADDR),
      .IN_MUTE_BIT  (IN_MUTE_BIT),
      .OUT_MUTE_BIT (OUT_MUTE_BIT)
   ) u_regs (
      .clk       (clk),
      .pdn_n     (pdn_n),
      .busy      (busy),
      .valid     (valid),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .regs_flat (ctl_regs),
      .drop      (guard_drop),
      .in_arm    (in_arm),
      .out_arm   (out_arm)
   );

   assign adc_pwr    = ctl_regs[PM_ADDR*REG_W + PM_ADC_BIT];
   assign force_zero = busy || !adc_pwr;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic signed [SAMPLE_W-1:0] off;

      cal_offset_mem #(
         .SAMPLE_W (SAMPLE_W),
         .AVG_SH   (AVG_SH)
      ) u_off (
         .clk    (clk),
         .pdn_n  (pdn_n),
         .take   (avg_take),
         .done   (done),
         .sample (adc_in[c*SAMPLE_W +: SAMPLE_W]),
         .offset (off)
      );

      cal_adc_gate #(
         .SAMPLE_W (SAMPLE_W)
      ) u_gate (
         .force_zero (force_zero),
         .sample     (adc_in[c*SAMPLE_W +: SAMPLE_W]),
         .offset     (off),
         .result     (adc_out[c*SAMPLE_W +: SAMPLE_W])
      );
   end

   assign in_gain_mute  = !(valid && in_arm);
   assign out_gain_mute = !(valid && out_arm);
   assign cal_busy      = busy;
   assign cal_valid     = valid;

   // R3: the data path is silent while the window is open
   a_r3_zero_in_window: assert property (@(posedge clk) disable iff (!pdn_n)
      busy |-> adc_out == '0);

   // R4: both stages stay muted until a result exists
   a_r4_mute_without_result: assert property (@(posedge clk) disable iff (!pdn_n)
      !valid |-> in_gain_mute && out_gain_mute);

endmodule

// File: tb/sim_codec_cal_seq.sv
module sim_codec_cal_seq;

   localparam int W       = 16;
   localparam int CAL_LEN = 4128;
   localparam int AVG_N   = 4096;
   localparam longint MAXV = 32767;
   localparam longint MINV = -32768;

   logic        clk = 1'b0;
   logic        pdn_n = 1'b0;
   logic        fs_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [31:0] adc_in = '0;
   logic [31:0] adc_out;
   logic        in_gain_mute, out_gain_mute, cal_busy, cal_valid, guard_drop;
   logic [31:0] ctl_regs;

   int total = 0;
   int bad = 0;
   bit auto_stim = 1'b0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   codec_cal_seq u0 (
      .clk(clk), .pdn_n(pdn_n), .fs_tick(fs_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .adc_in(adc_in), .adc_out(adc_out),
      .in_gain_mute(in_gain_mute), .out_gain_mute(out_gain_mute),
      .cal_busy(cal_busy), .cal_valid(cal_valid), .guard_drop(guard_drop),
      .ctl_regs(ctl_regs)
   );

   // ---------------- reference model ----------------
   bit          m_busy, m_valid, m_drop, m_arm_in, m_arm_out;
   logic [7:0]  m_regs [4];
   int          m_ticks;
   longint      m_acc [2];
   longint      m_off [2];

   always @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         m_busy = 1; m_valid = 0; m_drop = 0; m_arm_in = 0; m_arm_out = 0;
         m_regs[0] = 8'h09; m_regs[1] = 0; m_regs[2] = 0; m_regs[3] = 0;
         m_ticks = 0;
         for (int c = 0; c < 2; c++) begin m_acc[c] = 0; m_off[c] = 0; end
      end else begin
         bit was_busy, was_valid;
         was_busy = m_busy; was_valid = m_valid;
         if (wr_en) begin
            if (wr_addr == 1 && was_busy) m_drop = 1;
            else if (wr_addr < 4) m_regs[wr_addr] = wr_data;
            if (wr_addr == 2 && was_valid) begin
               m_arm_in = wr_data[0]; m_arm_out = wr_data[1];
            end
         end
         if (was_busy && fs_tick) begin
            if (m_ticks >= CAL_LEN - AVG_N)
               for (int c = 0; c < 2; c++)
                  m_acc[c] += longint'($signed(adc_in[c*W +: W]));
            if (m_ticks == CAL_LEN - 1) begin
               m_busy = 0; m_valid = 1;
               for (int c = 0; c < 2; c++) m_off[c] = m_acc[c] >>> 12;
            end
            m_ticks++;
         end
      end
   end

   function automatic longint exp_out(int c);
      longint d;
      if (m_busy || !m_regs[0][0]) return 0;
      d = longint'($signed(adc_in[c*W +: W])) - m_off[c];
      if (d > MAXV) d = MAXV;
      if (d < MINV) d = MINV;
      return d;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison away from the active edge
   always @(negedge clk) begin
      longint e0, e1, a0, a1;
      logic [31:0] er;
      er = {m_regs[3], m_regs[2], m_regs[1], m_regs[0]};
      e0 = exp_out(0); e1 = exp_out(1);
      a0 = longint'($signed(adc_out[15:0])); a1 = longint'($signed(adc_out[31:16]));
      chk(cal_busy == m_busy, "R2 cal_busy", cal_busy, m_busy);
      chk(cal_valid == m_valid, "R8 cal_valid", cal_valid, m_valid);
      chk(guard_drop == m_drop, "R5 guard_drop", guard_drop, m_drop);
      chk(ctl_regs == er, "R6 ctl_regs", ctl_regs, er);
      chk(in_gain_mute == !(m_valid && m_arm_in), "R4 in_gain_mute", in_gain_mute, !(m_valid && m_arm_in));
      chk(out_gain_mute == !(m_valid && m_arm_out), "R4 out_gain_mute", out_gain_mute, !(m_valid && m_arm_out));
      chk(a0 == e0, "R7 adc ch0", a0, e0);
      chk(a1 == e1, "R7 adc ch1", a1, e1);
   end

   // ---------------- stimulus helpers ----------------
   always @(posedge clk) begin
      #1;
      cyc++;
      fs_tick = (cyc % 4 == 0);
      if (auto_stim)
         adc_in = {16'((cyc * 13) % 301 - 150), 16'((cyc * 37) % 201 - 100)};
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 0;
   endtask

   task automatic wait_done();
      int guard;
      guard = 0;
      while (cal_busy && guard < 40000) begin step(1); guard++; end
      step(1);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      step(3);
      // R1: defaults while held in power-down
      chk(ctl_regs == 32'h0000_0009, "R1 defaults", ctl_regs, 32'h9);
      chk(!cal_valid && !guard_drop && cal_busy, "R1 flags", {cal_valid, guard_drop, cal_busy}, 3'b001);
      chk(in_gain_mute && out_gain_mute, "R1 mutes", {in_gain_mute, out_gain_mute}, 2'b11);

      pdn_n = 1; auto_stim = 1;
      step(100);
      wr(4'd1, 8'h5A);        // guarded, dropped
      wr(4'd2, 8'h03);        // stored, arms nothing
      wr(4'd3, 8'hC3);
      step(2);
      chk(ctl_regs[15:8] == 8'h00, "R5 guarded reg unchanged", ctl_regs[15:8], 0);
      chk(guard_drop == 1'b1, "R5 drop flag set", guard_drop, 1);
      chk(adc_out == 32'h0, "R3 zero during window", adc_out, 0);
      wait_done();
      chk(cal_valid && in_gain_mute && out_gain_mute, "R4 muted after window",
          {cal_valid, in_gain_mute, out_gain_mute}, 3'b111);
      wr(4'd2, 8'h01);
      step(1);
      chk(!in_gain_mute && out_gain_mute, "R4 input stage released only",
          {in_gain_mute, out_gain_mute}, 2'b01);
      wr(4'd1, 8'h77);
      wr(4'd9, 8'hFF);
      step(1);
      chk(ctl_regs[15:8] == 8'h77, "R6 guarded reg writable after window", ctl_regs[15:8], 8'h77);
      step(300);
      wr(4'd0, 8'h08);        // ADC power off
      step(1);
      chk(adc_out == 32'h0 && cal_valid, "R8 powered-down ADC", adc_out, 0);
      wr(4'd0, 8'h01);        // aux off, ADC on
      step(300);
      chk(cal_valid == 1'b1, "R8 valid kept", cal_valid, 1);
      wr(4'd2, 8'h00);
      step(1);
      chk(in_gain_mute && out_gain_mute, "R4 remute", {in_gain_mute, out_gain_mute}, 2'b11);

      // abort a window with a short power-down pulse
      auto_stim = 0;
      adc_in = {16'sd1000, -16'sd1000};
      pdn_n = 0; step(2); pdn_n = 1;
      step(2000);
      pdn_n = 0; step(2);
      chk(!cal_valid && !guard_drop, "R1 pulse clears result", cal_valid, 0);
      pdn_n = 1;
      wait_done();
      adc_in = {-16'sd32768, 16'sd32767};
      step(1);
      chk(adc_out[15:0] == 16'h7FFF, "R7 saturate high", adc_out[15:0], 16'h7FFF);
      chk(adc_out[31:16] == 16'h8000, "R7 saturate low", adc_out[31:16], 16'h8000);
      adc_in = 32'h0;
      step(1);
      chk($signed(adc_out[15:0]) == 1000, "R7 offset ch0", $signed(adc_out[15:0]), 1000);
      chk($signed(adc_out[31:16]) == -1000, "R7 offset ch1", $signed(adc_out[31:16]), -1000);
      step(50);
      chk(!cal_busy, "R2 no reopen", cal_busy, 0);
      step(5);
      finish_run();
   end

endmodule